// File: doc/BRIEF.md
# Two-Port Synchronous Word Store with Per-Port Output Timing

This block is a word-wide memory with two fully independent access ports. Each port has its own clock and its own reset. Each port can read or write any word at any time. A port is chosen by a pair of enables, one active low and one active high. A read/write level selects the operation, and two active-low lane selects mark the lower and upper halves of the word. Every input except the output enable is sampled on the rising edge of the port's clock.

Each port picks its own output timing with a mode pin. In flow-through timing, read data appears in the cycle right after the edge that captured the address. In registered timing, the data passes through one more register and arrives a cycle later. Real tri-state pins are replaced by a per-lane drive flag. A lane that is not driven reads as zero on the data bus. The output enable gates the flags combinationally, with no clock involved.

The ports carry fixed-latency memory traffic and cannot apply back-pressure. For that reason they use plain control pins rather than a valid/ready handshake. The lower lane is the low `DATA_W/2` bits and the upper lane is the remaining bits: 9+9 for 18-bit words and 8+8 for 16-bit words.

Top module: `twin_port_sram`

## Requirements
- R1: A port acts only in cycles where its `ce0_n` is 0 and its `ce1` is 1 at the edge. With `ce0_n`=1 or `ce1`=0, a write leaves memory unchanged, and from the next edge on the port reports no read.
- R2: `we_n`=0 on a selected edge writes the addressed word. Only the lanes whose select is 0 are updated: `bsel_n[0]` covers bits `DATA_W/2-1:0` and `bsel_n[1]` covers the rest. Unselected lanes keep their old contents.
- R3: With `pipe`=0 sampled at edge N, a selected read (`we_n`=1) at edge N presents its data and drive flags from just after edge N until edge N+1.
- R4: With `pipe`=1 sampled at edges N and N+1, a selected read at edge N presents its data and drive flags from just after edge N+1 until edge N+2.
- R5: Drive flag `drive[i]` is 1 only for a read whose `bsel_n[i]` was 0 at its edge, while `oe_n` is 0. Data bits of an undriven lane read as 0.
- R6: `oe_n` acts asynchronously: raising it clears both drive flags and zeroes `rdata` with no clock edge, and lowering it restores them.
- R7: After a deselect, flow-through outputs are off from the next edge. Registered outputs are off from the second edge, because each cycle's output state follows the controls of the previous cycle.
- R8: A write cycle drives no lane in the cycle where its result would otherwise appear.
- R9: A word written by either port is read back by both ports. A read at edge N returns the word including all writes made at edges up to and including N, and excludes later writes.
- R10: When both ports write the same word at the same edge, that word's content is undefined. Every other word is unaffected.
- R11: While a port's `rst_n` is 0, its drive flags are 0. Memory contents are not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Port A clock |
| a_rst_n | input | 1 | Port A output-state reset, active low |
| a_ce0_n | input | 1 | Port A enable, active low |
| a_ce1 | input | 1 | Port A enable, active high |
| a_we_n | input | 1 | Port A write (0) / read (1) |
| a_bsel_n | input | 2 | Port A lane selects, active low, [0]=lower, [1]=upper |
| a_oe_n | input | 1 | Port A asynchronous output enable, active low |
| a_pipe | input | 1 | Port A timing: 0 flow-through, 1 registered |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data, undriven lanes zero |
| a_drive | output | 2 | Port A per-lane drive flags |
| b_clk | input | 1 | Port B clock |
| b_rst_n | input | 1 | Port B output-state reset, active low |
| b_ce0_n | input | 1 | Port B enable, active low |
| b_ce1 | input | 1 | Port B enable, active high |
| b_we_n | input | 1 | Port B write (0) / read (1) |
| b_bsel_n | input | 2 | Port B lane selects, active low |
| b_oe_n | input | 1 | Port B asynchronous output enable, active low |
| b_pipe | input | 1 | Port B timing: 0 flow-through, 1 registered |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data, undriven lanes zero |
| b_drive | output | 2 | Port B per-lane drive flags |

## Verification
A wrong stage-one control register shows on the drive flags just after the next edge in flow-through timing, and one edge later in registered timing. The bench checks both ports at every falling edge, so such a fault is caught within two cycles. A corrupted stored word cannot hide in one port. The bench also catches a bad lane mask or write gate at the first later read of that word, which it cross-checks against a reference copy from both ports. It mixes random traffic with directed deselect, lane-mask, same-word collision and output-enable cases.

// File: rtl/tps_pkg.sv
package tps_pkg;
  typedef enum logic {
    OUT_FLOW = 1'b0,
    OUT_PIPE = 1'b1
  } out_mode_e;

  localparam int LANES = 2;
endpackage

// File: rtl/tps_bank.sv
module tps_bank #(
  parameter int DW  = 18,
  parameter int AW  = 10,
  parameter int NRD = 3
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [1:0]               lane_en,
  input  logic [AW-1:0]            waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [NRD-1:0][AW-1:0]   raddr,
  output logic [NRD-1:0][DW-1:0]   rdata
);
  localparam int DEPTH = 1 << AW;
  localparam int LW    = DW / 2;
  localparam logic [DW-1:0] LO_MASK = {{(DW-LW){1'b0}}, {LW{1'b1}}};

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] wmask;

  assign wmask = ({DW{lane_en[0]}} & LO_MASK) | ({DW{lane_en[1]}} & ~LO_MASK);

  // single writer per bank; lanes outside the mask keep their bits
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= (mem[waddr] & ~wmask) | (wdata & wmask);
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rdata[r] = mem[raddr[r]];
  end
endmodule

// File: rtl/tps_port.sv
module tps_port
  import tps_pkg::*;
#(
  parameter int DW = 18,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce0_n,
  input  logic          ce1,
  input  logic          we_n,
  input  logic [1:0]    bsel_n,
  input  logic          oe_n,
  input  logic          pipe,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] word,
  output logic          wr_en,
  output logic [1:0]    wr_lanes,
  output logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rdata,
  output logic [1:0]    drive
);
  localparam int LW = DW / 2;
  localparam logic [DW-1:0] LO_MASK = {{(DW-LW){1'b0}}, {LW{1'b1}}};

  logic          sel;
  logic          rd_q, rd2_q;
  logic [1:0]    len_q, len2_q;
  out_mode_e     mode_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data2_q;
  logic          act;
  logic [1:0]    act_lanes;
  logic [DW-1:0] src;
  logic [DW-1:0] omask;

  assign sel      = !ce0_n && ce1;
  assign wr_en    = sel && !we_n;
  assign wr_lanes = ~bsel_n;
  assign rd_addr  = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      rd2_q  <= 1'b0;
      len_q  <= 2'b00;
      len2_q <= 2'b00;
      mode_q <= OUT_FLOW;
    end else begin
      rd_q   <= sel && we_n;
      len_q  <= ~bsel_n;
      rd2_q  <= rd_q;
      len2_q <= len_q;
      mode_q <= out_mode_e'(pipe);
    end
  end

  always_ff @(posedge clk) begin
    addr_q  <= addr;
    data2_q <= word;
  end

  always_comb begin
    if (mode_q == OUT_PIPE) begin
      act       = rd2_q;
      act_lanes = len2_q;
      src       = data2_q;
    end else begin
      act       = rd_q;
      act_lanes = len_q;
      src       = word;
    end
  end

  assign drive = {2{act && !oe_n}} & act_lanes;
  assign omask = ({DW{drive[0]}} & LO_MASK) | ({DW{drive[1]}} & ~LO_MASK);
  assign rdata = src & omask;

  a_r7_flow_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel && !pipe) |=> (drive == 2'b00));
  a_r7_pipe_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel && pipe) ##1 pipe |=> (drive == 2'b00));
  a_r8_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !pipe) |=> (drive == 2'b00));
  a_r5_lane_flow: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe && sel && we_n && !bsel_n[0]) |=> (drive[0] || oe_n));
  a_r4_pipe_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe && sel && we_n && !bsel_n[1]) ##1 pipe |=> (drive[1] || oe_n));
endmodule

// File: rtl/twin_port_sram.sv
module twin_port_sram #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 10
) (
  input  logic              a_clk,
  input  logic              a_rst_n,
  input  logic              a_ce0_n,
  input  logic              a_ce1,
  input  logic              a_we_n,
  input  logic [1:0]        a_bsel_n,
  input  logic              a_oe_n,
  input  logic              a_pipe,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic [1:0]        a_drive,
  input  logic              b_clk,
  input  logic              b_rst_n,
  input  logic              b_ce0_n,
  input  logic              b_ce1,
  input  logic              b_we_n,
  input  logic [1:0]        b_bsel_n,
  input  logic              b_oe_n,
  input  logic              b_pipe,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic [1:0]        b_drive
);
  localparam int NRD = 3;

  logic                          a_wr, b_wr;
  logic [1:0]                    a_wl, b_wl;
  logic [ADDR_W-1:0]             a_ra, b_ra;
  logic [NRD-1:0][DATA_W-1:0]    bank_a_q, bank_b_q;
  logic [DATA_W-1:0]             a_word, b_word;
  logic [DATA_W-1:0]             a_wx, b_wx;

  // read slot 0: the other port's write address, 1: port A read, 2: port B read
  tps_bank #(.DW(DATA_W), .AW(ADDR_W), .NRD(NRD)) u_bank_a (
    .clk(a_clk), .we(a_wr), .lane_en(a_wl), .waddr(a_addr), .wdata(a_wx),
    .raddr({b_ra, a_ra, b_addr}), .rdata(bank_a_q));

  tps_bank #(.DW(DATA_W), .AW(ADDR_W), .NRD(NRD)) u_bank_b (
    .clk(b_clk), .we(b_wr), .lane_en(b_wl), .waddr(b_addr), .wdata(b_wx),
    .raddr({b_ra, a_ra, a_addr}), .rdata(bank_b_q));

  // each bank stores value XOR the other bank, so a word is the XOR of both
  assign a_wx   = a_wdata ^ bank_b_q[0];
  assign b_wx   = b_wdata ^ bank_a_q[0];
  assign a_word = bank_a_q[1] ^ bank_b_q[1];
  assign b_word = bank_a_q[2] ^ bank_b_q[2];

  tps_port #(.DW(DATA_W), .AW(ADDR_W)) u_port_a (
    .clk(a_clk), .rst_n(a_rst_n), .ce0_n(a_ce0_n), .ce1(a_ce1), .we_n(a_we_n),
    .bsel_n(a_bsel_n), .oe_n(a_oe_n), .pipe(a_pipe), .addr(a_addr), .word(a_word),
    .wr_en(a_wr), .wr_lanes(a_wl), .rd_addr(a_ra), .rdata(a_rdata), .drive(a_drive));

  tps_port #(.DW(DATA_W), .AW(ADDR_W)) u_port_b (
    .clk(b_clk), .rst_n(b_rst_n), .ce0_n(b_ce0_n), .ce1(b_ce1), .we_n(b_we_n),
    .bsel_n(b_bsel_n), .oe_n(b_oe_n), .pipe(b_pipe), .addr(b_addr), .word(b_word),
    .wr_en(b_wr), .wr_lanes(b_wl), .rd_addr(b_ra), .rdata(b_rdata), .drive(b_drive));
endmodule

// File: tb/twin_port_sram_test.sv
module twin_port_sram_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW    = 18;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;
  localparam int LW    = DW / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic          ce0_n [2];
  logic          ce1   [2];
  logic          we_n  [2];
  logic          oe_n  [2];
  logic          pipe  [2];
  logic [1:0]    bsel_n[2];
  logic [AW-1:0] addr  [2];
  logic [DW-1:0] wdata [2];
  logic [DW-1:0] rdata [2];
  logic [1:0]    drive [2];

  logic [DW-1:0] ref_mem [DEPTH];
  logic          ref_ok  [DEPTH];
  logic          m1_rd[2], m1_pipe[2], m2_rd[2], m2_ok[2];
  logic [1:0]    m1_ln[2], m2_ln[2];
  logic [AW-1:0] m1_addr[2];
  logic [DW-1:0] m2_data[2];
  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twin_port_sram #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .a_clk(clk), .a_rst_n(rst_n), .a_ce0_n(ce0_n[0]), .a_ce1(ce1[0]), .a_we_n(we_n[0]),
    .a_bsel_n(bsel_n[0]), .a_oe_n(oe_n[0]), .a_pipe(pipe[0]), .a_addr(addr[0]),
    .a_wdata(wdata[0]), .a_rdata(rdata[0]), .a_drive(drive[0]),
    .b_clk(clk), .b_rst_n(rst_n), .b_ce0_n(ce0_n[1]), .b_ce1(ce1[1]), .b_we_n(we_n[1]),
    .b_bsel_n(bsel_n[1]), .b_oe_n(oe_n[1]), .b_pipe(pipe[1]), .b_addr(addr[1]),
    .b_wdata(wdata[1]), .b_rdata(rdata[1]), .b_drive(drive[1]));

  function automatic logic [DW-1:0] lane_mask(logic [1:0] on);
    logic [DW-1:0] lo;
    lo = {{(DW-LW){1'b0}}, {LW{1'b1}}};
    return ({DW{on[0]}} & lo) | ({DW{on[1]}} & ~lo);
  endfunction

  function automatic bit is_sel(int p);
    return !ce0_n[p] && ce1[p];
  endfunction

  task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  // reference update for one rising edge (R9/R10 ordering rules)
  task automatic model_edge();
    bit w0, w1;
    for (int p = 0; p < 2; p++) begin
      m2_rd[p]   = m1_rd[p];
      m2_ln[p]   = m1_ln[p];
      m2_data[p] = ref_mem[m1_addr[p]];
      m2_ok[p]   = ref_ok[m1_addr[p]];
    end
    w0 = is_sel(0) && !we_n[0];
    w1 = is_sel(1) && !we_n[1];
    if (w0 && w1 && addr[0] == addr[1]) begin
      ref_ok[addr[0]] = 1'b0;
    end else begin
      for (int p = 0; p < 2; p++) begin
        if ((p == 0 && w0) || (p == 1 && w1)) begin
          ref_mem[addr[p]] = (ref_mem[addr[p]] & ~lane_mask(~bsel_n[p])) |
                             (wdata[p] & lane_mask(~bsel_n[p]));
          if (bsel_n[p] == 2'b00) ref_ok[addr[p]] = 1'b1;
        end
      end
    end
    for (int p = 0; p < 2; p++) begin
      m1_rd[p]   = is_sel(p) && we_n[p];
      m1_ln[p]   = ~bsel_n[p];
      m1_addr[p] = addr[p];
      m1_pipe[p] = pipe[p];
    end
  endtask

  task automatic check_port(int p, string tag);
    logic rd, ok;
    logic [1:0] ln, ed;
    logic [DW-1:0] d, m;
    if (m1_pipe[p]) begin
      rd = m2_rd[p]; ln = m2_ln[p]; d = m2_data[p]; ok = m2_ok[p];
    end else begin
      rd = m1_rd[p]; ln = m1_ln[p]; d = ref_mem[m1_addr[p]]; ok = ref_ok[m1_addr[p]];
    end
    ed = {2{rd && !oe_n[p]}} & ln;
    m  = lane_mask(ed);
    chk(drive[p] == ed, {tag, " R5 drive"}, DW'(drive[p]), DW'(ed));
    if (ok) chk(rdata[p] == (d & m), {tag, " data"}, rdata[p], d & m);
    else    chk((rdata[p] & ~m) == '0, {tag, " R5 undriven zero"}, rdata[p], '0);
  endtask

  task automatic step(string tag);
    @(posedge clk);
    #1;
    if (rst_n) model_edge();
    @(negedge clk);
    check_port(0, tag);
    check_port(1, tag);
  endtask

  task automatic drv(int p, bit sel, bit wr, logic [1:0] bn, int a, logic [DW-1:0] d,
                     bit pp, bit oe);
    ce0_n[p] = !sel; ce1[p] = sel; we_n[p] = !wr; bsel_n[p] = bn;
    addr[p] = AW'(a); wdata[p] = d; pipe[p] = pp; oe_n[p] = oe;
  endtask

  task automatic idle(int p);
    drv(p, 1'b0, 1'b0, 2'b11, 0, '0, pipe[p], 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL R9 watchdog expired: actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h0005_eed1));
    for (int w = 0; w < DEPTH; w++) begin ref_mem[w] = '0; ref_ok[w] = 1'b0; end
    for (int p = 0; p < 2; p++) begin
      m1_rd[p] = 0; m1_pipe[p] = 0; m2_rd[p] = 0; m2_ok[p] = 0;
      m1_ln[p] = 0; m2_ln[p] = 0; m1_addr[p] = 0; m2_data[p] = 0;
      pipe[p] = 1'b0; idle(p);
    end
    repeat (3) @(negedge clk);
    // R11: reset holds flags low
    chk(drive[0] == 2'b00 && drive[1] == 2'b00, "R11 reset",
        DW'({drive[0], drive[1]}), '0);
    rst_n = 1'b1;

    // preload every word through port A, flow-through
    for (int w = 0; w < DEPTH; w++) begin
      drv(0, 1, 1, 2'b00, w, DW'($urandom), 0, 0);
      step("R2 preload");
    end
    idle(0);
    // R9: port B reads what port A wrote
    for (int w = 0; w < 8; w++) begin
      drv(1, 1, 0, 2'b00, w, '0, 0, 0);
      step("R9 R3 cross read");
    end
    idle(1);

    // R2: upper-lane-only write, then full read
    drv(0, 1, 1, 2'b01, 10, '1, 0, 0);
    step("R2 lane write");
    drv(0, 1, 0, 2'b00, 10, '0, 0, 0);
    step("R2 lane readback");

    // R8: a write cycle drives nothing
    drv(0, 1, 1, 2'b00, 11, DW'(18'h2A5A5), 0, 0);
    step("R8");
    chk(drive[0] == 2'b00, "R8 write quiet", DW'(drive[0]), '0);

    // R1: writes with either enable inactive are dropped
    drv(0, 1, 1, 2'b00, 12, DW'(18'h1111), 0, 0); ce1[0] = 1'b0;
    step("R1");
    chk(drive[0] == 2'b00, "R1 deselect no drive", DW'(drive[0]), '0);
    drv(0, 1, 1, 2'b00, 12, DW'(18'h2222), 0, 0); ce0_n[0] = 1'b1;
    step("R1");
    drv(0, 1, 0, 2'b00, 12, '0, 0, 0);
    step("R1 readback");

    // R6: output enable without a clock
    idle(0);
    drv(1, 1, 0, 2'b00, 3, '0, 0, 0);
    step("R6");
    oe_n[1] = 1'b1; #1;
    check_port(1, "R6 oe high");
    chk(drive[1] == 2'b00 && rdata[1] == '0, "R6 oe high off", rdata[1], '0);
    oe_n[1] = 1'b0; #1;
    check_port(1, "R6 oe low");

    // R4: registered timing latency
    drv(1, 1, 0, 2'b00, 4, '0, 1, 0);
    step("R4 first edge");
    idle(1);
    step("R4 second edge");
    chk(drive[1] == 2'b11, "R4 data after two edges", DW'(drive[1]), DW'(2'b11));

    // R7: registered deselect then reselect
    drv(1, 1, 0, 2'b10, 5, '0, 1, 0);
    step("R7 read");
    idle(1);
    step("R7 deselect edge");
    chk(drive[1] == 2'b01, "R7 still previous read", DW'(drive[1]), DW'(2'b01));
    drv(1, 1, 0, 2'b00, 6, '0, 1, 0);
    step("R7 reselect edge");
    chk(drive[1] == 2'b00, "R7 off after deselect", DW'(drive[1]), '0);
    idle(1);
    step("R7 reactivated");
    chk(drive[1] == 2'b11, "R7 driven again", DW'(drive[1]), DW'(2'b11));
    pipe[1] = 1'b0;

    // R10: same word written by both ports
    drv(0, 1, 1, 2'b00, 20, DW'(18'h0F0F0), 0, 0);
    drv(1, 1, 1, 2'b00, 20, DW'(18'h30303), 0, 0);
    step("R10 collide");
    drv(0, 1, 0, 2'b00, 21, '0, 0, 0);
    drv(1, 1, 0, 2'b00, 19, '0, 0, 0);
    step("R10 neighbours");
    idle(0); idle(1);
    step("R10");

    // constrained random traffic on both ports
    for (int c = 0; c < 3000; c++) begin
      for (int p = 0; p < 2; p++) begin
        bit s;
        logic pp;
        pp = pipe[p];
        if ($urandom % 40 == 0) pp = ~pp;
        s = ($urandom % 6) != 0;
        drv(p, s, ($urandom % 2) == 1, 2'($urandom), int'($urandom % DEPTH),
            DW'($urandom), pp, ($urandom % 5) == 0);
        if (!s && ($urandom % 2) == 1) begin ce0_n[p] = 1'b0; ce1[p] = 1'b0; end
      end
      step("R9 R3 R4 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule